// File: doc/BRIEF.md
# Descriptor-Fetching DMA Transfer Engine

This block is the execution core of a multi-channel DMA controller whose per-channel control data is held in a descriptor table in system memory. When a channel is selected, the engine builds that channel's descriptor address from a table base. It reads the descriptor's three live fields over a single memory port, moves one item from source to destination, and writes the updated control word back to the table. The fields are the source end pointer, the destination end pointer and the control word.

Descriptors store end pointers and a count kept as "items left minus one". Each item address is therefore worked out backward from the end pointer. The first item moved sits at the lowest address, and the last sits exactly at the end pointer. After each item the engine returns to idle so that an outside arbiter can choose the next channel. The channel's done pulse fires when the item just moved was the last one. Only the basic cycle type is run. A descriptor with an illegal size code, or one that is not in the basic state, is rejected with an error pulse.

Top module: `dxe_engine`

## Requirements
- R1: The descriptor address is the table base with its low bits cleared, OR-ed with the descriptor field index at bits 3:2 and the channel number starting at bit 4. The alternate-list select sits just above the channel number. Bits 1:0 are zero. With up to 8 channels the channel uses bits 6:4, the alternate select is bit 7, and the base is aligned to 256 bytes. With up to 16 channels the channel uses bits 7:4, the alternate select is bit 8, and the base is aligned to 512 bytes.
- R2: After a request is accepted, the first three memory accesses are word reads of field 0 (source end pointer, offset 0), field 1 (destination end pointer, offset 4) and field 2 (control word, offset 8), in that order.
- R3: Control word encoding: bits 1:0 cycle state (01 basic, 00 stopped); bits 13:4 items left minus one; bits 25:24 item size code (0 byte, 1 halfword, 2 word, 3 illegal); bit 28 source increments; bit 30 destination increments. All other bits are carried through unchanged.
- R4: An incrementing side addresses its item at end − (count_minus_1 << size). A non-incrementing side always uses the end pointer itself.
- R5: One item moves per request: one read of the source address, then one write of the destination address. Both use mem_size equal to the size code. Data is right-aligned, and the read data is written unchanged.
- R6: After the item, the control word is written back as a word to offset 8. If the count was nonzero, the count is decremented by one. If the count was zero, the cycle state becomes 00 and the count stays 0. Every other bit is unchanged.
- R7: done pulses for one cycle on bit `chan` in the cycle after the write-back is accepted, and only when the count read was zero. It never pulses otherwise.
- R8: A control word with size code 3, or with a cycle state other than 01, causes no transfer and no write-back. Instead err pulses for one cycle on bit `chan` in the cycle after the control word read is accepted.
- R9: A memory request holds its address, direction, size and write data until mem_ack is seen. Stalls only delay the sequence.
- R10: req_valid is taken only while busy is low. A request presented while busy is ignored, and no memory access is made while idle.
- R11: Under synchronous reset, busy, mem_req, done and err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | ADDR_W | Descriptor table base address |
| req_valid | input | 1 | Run one item for the selected channel |
| req_chan | input | CH_W | Selected channel number |
| req_alt | input | 1 | Use the alternate descriptor list |
| busy | output | 1 | Engine is working on a request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 2 | Access size code (0 byte, 1 half, 2 word) |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned, valid with mem_ack |
| mem_ack | input | 1 | Access accepted this cycle |
| done | output | NUM_CH | Per-channel last-item pulse |
| err | output | NUM_CH | Per-channel rejected-descriptor pulse |

## Verification
A multi-item word descriptor with both sides incrementing shows whether the backward address arithmetic and the count write-back line up item by item. A byte descriptor with a fixed source and a stepping destination separates the two increment settings, because the fixed source's content is changed between items. A single-item halfword descriptor on the alternate list exercises the zero-count, stop-state and alternate-select path. Descriptors with size code 3, and a descriptor already stopped, must produce only the three descriptor reads and an error pulse. Random memory stalls and a competing request held during a busy period show that only the timing moves.

// File: rtl/dxe_pkg.sv
package dxe_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 10;

    localparam logic [1:0] CYC_STOP  = 2'b00;
    localparam logic [1:0] CYC_BASIC = 2'b01;

    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;

    // control word overlay, bit 0 at the bottom
    typedef struct packed {
        logic             spare_hi;
        logic             dst_step;
        logic             spare_b;
        logic             src_step;
        logic [1:0]       spare_c;
        logic [1:0]       size;
        logic [9:0]       spare_d;
        logic [CNT_W-1:0] left_m1;
        logic [1:0]       spare_e;
        logic [1:0]       cycle;
    } ctl_word_t;

    typedef enum logic [1:0] {
        FLD_SRC = 2'd0,
        FLD_DST = 2'd1,
        FLD_CTL = 2'd2,
        FLD_USR = 2'd3
    } desc_field_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC,
        ST_DST,
        ST_CTL,
        ST_RD,
        ST_WR,
        ST_WB
    } eng_state_e;

    function automatic int chan_bits(input int n);
        return (n <= 8) ? 3 : 4;
    endfunction

    function automatic logic ctl_runnable(input ctl_word_t c);
        return (c.cycle == CYC_BASIC) && (c.size != SZ_BAD);
    endfunction

endpackage

// File: rtl/dxe_desc_addr.sv
module dxe_desc_addr #(
    parameter int ADDR_W = 32,
    parameter int CH_W   = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              alt,
    input  logic [CH_W-1:0]   chan,
    input  logic [1:0]        field,
    output logic [ADDR_W-1:0] addr
);
    localparam int LOW_W = CH_W + 5;
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << LOW_W) - 64'd1);

    logic [LOW_W-1:0] offs;

    assign offs = {alt, chan, field, 2'b00};
    assign addr = (base & ~LOW_MASK) | ADDR_W'(offs);
endmodule

// File: rtl/dxe_item_addr.sv
module dxe_item_addr
    import dxe_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] end_ptr,
    input  logic [CNT_W-1:0]  left_m1,
    input  logic [1:0]        size,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] back;

    always_comb begin
        back = ADDR_W'(left_m1) << size;
        addr = step ? (end_ptr - back) : end_ptr;
    end
endmodule

// File: rtl/dxe_ctl_next.sv
module dxe_ctl_next
    import dxe_pkg::*;
(
    input  ctl_word_t cur,
    output ctl_word_t nxt,
    output logic      last
);
    always_comb begin
        last = (cur.left_m1 == '0);
        nxt  = cur;
        if (last) begin
            nxt.cycle = CYC_STOP;
        end else begin
            nxt.left_m1 = cur.left_m1 - CNT_W'(1);
        end
    end
endmodule

// File: rtl/dxe_engine.sv
module dxe_engine
    import dxe_pkg::*;
#(
    parameter  int NUM_CH = 8,
    parameter  int ADDR_W = 32,
    localparam int CH_W   = chan_bits(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              req_alt,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [NUM_CH-1:0] done,
    output logic [NUM_CH-1:0] err
);
    localparam int SIDES = 2;

    eng_state_e        st_q;
    logic [CH_W-1:0]   chan_q;
    logic              alt_q;
    logic [ADDR_W-1:0] src_end_q;
    logic [ADDR_W-1:0] dst_end_q;
    logic [WORD_W-1:0] data_q;
    ctl_word_t         ctl_q;
    ctl_word_t         ctl_nxt;
    ctl_word_t         ctl_in;
    logic              last_item;
    logic [NUM_CH-1:0] done_q;
    logic [NUM_CH-1:0] err_q;
    logic [NUM_CH-1:0] chan_hot;
    desc_field_e       fld;
    logic [ADDR_W-1:0] desc_addr;

    logic [ADDR_W-1:0] side_end  [SIDES];
    logic              side_step [SIDES];
    logic [ADDR_W-1:0] side_addr [SIDES];

    assign ctl_in   = ctl_word_t'(mem_rdata);
    assign chan_hot = NUM_CH'(1) << chan_q;
    assign busy     = (st_q != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;

    assign side_end[0]  = src_end_q;
    assign side_step[0] = ctl_q.src_step;
    assign side_end[1]  = dst_end_q;
    assign side_step[1] = ctl_q.dst_step;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dxe_item_addr #(.ADDR_W(ADDR_W)) u_item (
            .end_ptr (side_end[s]),
            .left_m1 (ctl_q.left_m1),
            .size    (ctl_q.size),
            .step    (side_step[s]),
            .addr    (side_addr[s])
        );
    end

    dxe_desc_addr #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_desc (
        .base  (tbl_base),
        .alt   (alt_q),
        .chan  (chan_q),
        .field (fld),
        .addr  (desc_addr)
    );

    dxe_ctl_next u_next (
        .cur  (ctl_q),
        .nxt  (ctl_nxt),
        .last (last_item)
    );

    always_comb begin
        unique case (st_q)
            ST_DST:       fld = FLD_DST;
            ST_CTL, ST_WB: fld = FLD_CTL;
            default:      fld = FLD_SRC;
        endcase
    end

    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_size  = SZ_WORD;
        mem_wdata = '0;
        mem_addr  = desc_addr;
        unique case (st_q)
            ST_IDLE: mem_req = 1'b0;
            ST_SRC, ST_DST, ST_CTL: ;
            ST_RD: begin
                mem_addr = side_addr[0];
                mem_size = ctl_q.size;
            end
            ST_WR: begin
                mem_addr  = side_addr[1];
                mem_size  = ctl_q.size;
                mem_we    = 1'b1;
                mem_wdata = data_q;
            end
            ST_WB: begin
                mem_we    = 1'b1;
                mem_wdata = ctl_nxt;
            end
            default: mem_req = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            chan_q    <= '0;
            alt_q     <= 1'b0;
            src_end_q <= '0;
            dst_end_q <= '0;
            data_q    <= '0;
            ctl_q     <= '0;
            done_q    <= '0;
            err_q     <= '0;
        end else begin
            done_q <= '0;
            err_q  <= '0;
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    chan_q <= req_chan;
                    alt_q  <= req_alt;
                    st_q   <= ST_SRC;
                end
                ST_SRC: if (mem_ack) begin
                    src_end_q <= ADDR_W'(mem_rdata);
                    st_q      <= ST_DST;
                end
                ST_DST: if (mem_ack) begin
                    dst_end_q <= ADDR_W'(mem_rdata);
                    st_q      <= ST_CTL;
                end
                ST_CTL: if (mem_ack) begin
                    ctl_q <= ctl_in;
                    if (ctl_runnable(ctl_in)) begin
                        st_q <= ST_RD;
                    end else begin
                        err_q <= chan_hot;
                        st_q  <= ST_IDLE;
                    end
                end
                ST_RD: if (mem_ack) begin
                    data_q <= mem_rdata;
                    st_q   <= ST_WR;
                end
                ST_WR: if (mem_ack) begin
                    st_q <= ST_WB;
                end
                ST_WB: if (mem_ack) begin
                    ctl_q <= ctl_nxt;
                    if (last_item) begin
                        done_q <= chan_hot;
                    end
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dxe_checker.sv
module dxe_checker #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic [31:0]       mem_wdata,
    input logic [NUM_CH-1:0] done,
    input logic [NUM_CH-1:0] err
);
    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req) else $error("idle access"); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_size) && $stable(mem_wdata)))
        else $error("request dropped or changed"); // R9

    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done)) else $error("done not one-hot"); // R7

    AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(err)) else $error("err not one-hot"); // R8

    AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
        (|done) |-> $past(mem_req && mem_ack && mem_we)) else $error("done without write-back"); // R7

    AST_ERR_AFTER_CTL: assert property (@(posedge clk) disable iff (rst)
        (|err) |-> $past(mem_req && mem_ack && !mem_we)) else $error("err not after a read"); // R8

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !((|done) && (|err))) else $error("done and err together"); // R8
endmodule

bind dxe_engine dxe_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .done      (done),
    .err       (err)
);

// File: tb/dxe_engine_tb.sv
`timescale 1ns/1ps
module dxe_engine_tb;
    localparam int NUM_CH = 8;
    localparam int ADDR_W = 32;
    localparam logic [31:0] TBL = 32'h0000_0400;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] tbl_base = TBL;
    logic              req_valid = 1'b0;
    logic [2:0]        req_chan = '0;
    logic              req_alt = 1'b0;
    logic              busy;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [1:0]        mem_size;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              mem_ack;
    logic [NUM_CH-1:0] done;
    logic [NUM_CH-1:0] err;

    int nerr = 0;
    int nchk = 0;
    logic stall_mode = 1'b0;
    logic stall = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    logic [7:0] mem [0:4095];

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [1:0]  kind;
    } acc_t;
    acc_t exp_q[$];
    int   ev_q[$];

    always #2 clk = ~clk;

    dxe_engine #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .tbl_base(tbl_base), .req_valid(req_valid),
        .req_chan(req_chan), .req_alt(req_alt), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .done(done), .err(err)
    );

    function automatic logic [31:0] mrd(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] v = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < (1 << sz)) v[i*8 +: 8] = mem[12'(a + 32'(i))];
        end
        return v;
    endfunction

    task automatic wr32(input logic [31:0] a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) mem[12'(a + 32'(i))] = v[i*8 +: 8];
    endtask

    // R3: control word encoding used by the bench
    function automatic logic [31:0] mk_ctl(input int nm1, input logic [1:0] sz,
                                           input bit sinc, input bit dinc, input logic [1:0] cyc);
        return (32'(dinc) << 30) | (32'(sinc) << 28) | (32'(sz) << 24)
             | ((32'(nm1) & 32'h3FF) << 4) | 32'(cyc);
    endfunction

    function automatic logic [31:0] daddr(input int ch, input bit alt, input int fld);
        return TBL | (32'(alt) << 7) | (32'(ch) << 4) | (32'(fld) << 2);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic string ktag(input logic [1:0] k);
        case (k)
            2'd0: return "R1/R2 descriptor read";
            2'd1: return "R4 source read";
            2'd2: return "R5 destination write";
            default: return "R6 write-back";
        endcase
    endfunction

    // R9: pseudo-random stalls on the memory port
    always @(posedge clk) begin
        lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        stall <= stall_mode & lfsr[0];
    end
    assign mem_ack = mem_req & ~stall;

    always @(negedge clk) mem_rdata <= mrd(mem_addr, mem_size);

    always @(posedge clk) begin
        if (mem_req && mem_ack && mem_we) begin
            for (int i = 0; i < 4; i++) begin
                if (i < (1 << mem_size)) mem[12'(mem_addr + 32'(i))] <= mem_wdata[i*8 +: 8];
            end
        end
    end

    // per-clock comparison against the reference sequence
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && mem_ack) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected access", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    acc_t e;
                    e = exp_q.pop_front();
                    chk(mem_addr == e.addr && mem_we == e.we && mem_size == e.size,
                        ktag(e.kind), mem_addr, e.addr);
                    if (e.we) chk(mem_wdata == e.wdata, ktag(e.kind), mem_wdata, e.wdata);
                end
            end
            if ((|done) || (|err)) begin
                if (ev_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected pulse", {16'(done), 16'(err)}, 32'h0);
                end else begin
                    int v;
                    logic [NUM_CH-1:0] ed, ee;
                    v  = ev_q.pop_front();
                    ed = (v < 100) ? NUM_CH'(1) << v : '0;
                    ee = (v >= 100) ? NUM_CH'(1) << (v - 100) : '0;
                    chk(done == ed && err == ee, (v >= 100) ? "R8 err pulse" : "R7 done pulse",
                        {16'(done), 16'(err)}, {16'(ed), 16'(ee)});
                end
            end
        end
    end

    task automatic issue(input int ch, input bit alt, input int other);
        logic [31:0] se, de, c, sa, da, nc;
        int nm1;
        logic [1:0] sz;
        se = mrd(daddr(ch, alt, 0), 2'd2);
        de = mrd(daddr(ch, alt, 1), 2'd2);
        c  = mrd(daddr(ch, alt, 2), 2'd2);
        for (int f = 0; f < 3; f++) exp_q.push_back({1'b0, daddr(ch, alt, f), 2'd2, 32'h0, 2'd0});
        sz  = c[25:24];
        nm1 = int'(c[13:4]);
        if (sz == 2'd3 || c[1:0] != 2'b01) begin
            ev_q.push_back(100 + ch);
        end else begin
            sa = c[28] ? se - (32'(nm1) << sz) : se;
            da = c[30] ? de - (32'(nm1) << sz) : de;
            exp_q.push_back({1'b0, sa, sz, 32'h0, 2'd1});
            exp_q.push_back({1'b1, da, sz, mrd(sa, sz), 2'd2});
            nc = c;
            if (nm1 == 0) nc[1:0] = 2'b00;
            else nc[13:4] = 10'(nm1 - 1);
            exp_q.push_back({1'b1, daddr(ch, alt, 2), 2'd2, nc, 2'd3});
            if (nm1 == 0) ev_q.push_back(ch);
        end
        @(negedge clk);
        while (busy) @(negedge clk);
        req_chan = 3'(ch); req_alt = alt; req_valid = 1'b1;
        @(negedge clk);
        if (other >= 0) begin
            // R10: competing request while busy must be ignored
            req_chan = 3'(other); req_alt = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
        req_valid = 1'b0;
        begin
            int t = 0;
            while ((exp_q.size() != 0 || ev_q.size() != 0 || busy) && t < 400) begin
                @(negedge clk);
                t++;
            end
            if (t >= 400) begin
                chk(1'b0, "R7 sequence timeout", 32'(exp_q.size()), 32'h0);
                exp_q.delete();
                ev_q.delete();
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL R7 watchdog expired actual=%0d expected=0", exp_q.size());
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!busy && !mem_req && done == '0 && err == '0, "R11 reset outputs",
            {28'h0, busy, mem_req, |done, |err}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req, "R11 idle after reset", {30'h0, busy, mem_req}, 32'h0);

        // word, both sides stepping, three items, channel 2
        wr32(32'h800, 32'h1111_AAAA); wr32(32'h804, 32'h2222_BBBB); wr32(32'h808, 32'h3333_CCCC);
        wr32(daddr(2, 0, 0), 32'h808);
        wr32(daddr(2, 0, 1), 32'hA08);
        wr32(daddr(2, 0, 2), mk_ctl(2, 2'd2, 1, 1, 2'b01) | 32'h8000_0000);
        issue(2, 0, -1);
        issue(2, 0, -1);
        issue(2, 0, 6);
        chk(mrd(32'hA00, 2'd2) == 32'h1111_AAAA, "R5 first word", mrd(32'hA00, 2'd2), 32'h1111_AAAA);
        chk(mrd(32'hA08, 2'd2) == 32'h3333_CCCC, "R5 last word", mrd(32'hA08, 2'd2), 32'h3333_CCCC);
        chk(mrd(daddr(2, 0, 2), 2'd2) == (mk_ctl(0, 2'd2, 1, 1, 2'b00) | 32'h8000_0000),
            "R6 stopped control", mrd(daddr(2, 0, 2), 2'd2), mk_ctl(0, 2'd2, 1, 1, 2'b00) | 32'h8000_0000);

        // stopped descriptor is rejected
        issue(2, 0, -1);

        // byte, fixed source, stepping destination, with stalls (R9)
        stall_mode = 1'b1;
        mem[12'h900] = 8'h5C;
        wr32(daddr(5, 0, 0), 32'h900);
        wr32(daddr(5, 0, 1), 32'hB01);
        wr32(daddr(5, 0, 2), mk_ctl(1, 2'd0, 0, 1, 2'b01));
        issue(5, 0, -1);
        mem[12'h900] = 8'hE7;
        issue(5, 0, 4);
        chk(mem[12'hB00] == 8'h5C, "R4 fixed source item 0", 32'(mem[12'hB00]), 32'h5C);
        chk(mem[12'hB01] == 8'hE7, "R4 fixed source item 1", 32'(mem[12'hB01]), 32'hE7);

        // illegal size code under stalls
        wr32(daddr(7, 0, 0), 32'h910);
        wr32(daddr(7, 0, 1), 32'hC40);
        wr32(daddr(7, 0, 2), mk_ctl(4, 2'd3, 1, 1, 2'b01));
        issue(7, 0, 1);
        chk(mrd(daddr(7, 0, 2), 2'd2) == mk_ctl(4, 2'd3, 1, 1, 2'b01), "R8 no write-back",
            mrd(daddr(7, 0, 2), 2'd2), mk_ctl(4, 2'd3, 1, 1, 2'b01));
        stall_mode = 1'b0;

        // halfword, single item, alternate list, channel 0
        wr32(daddr(0, 1, 0), 32'h920);
        wr32(daddr(0, 1, 1), 32'hC00);
        wr32(daddr(0, 1, 2), mk_ctl(0, 2'd1, 1, 0, 2'b01));
        issue(0, 1, -1);
        chk(mrd(32'hC00, 2'd1) == mrd(32'h920, 2'd1), "R5 halfword item",
            mrd(32'hC00, 2'd1), mrd(32'h920, 2'd1));

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0 && ev_q.size() == 0, "R7 nothing outstanding",
            32'(exp_q.size() + ev_q.size()), 32'h0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule